// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Order

This block produces the address for a four-beat burst in a synchronous burst memory. When a burst begins, it captures a full external address. On each later cycle where an advance request is present, the two least significant bits step to the next beat position. The upper bits do not change.

A static order-select input picks how the low bits step. With the input high, or with it left floating where a pull-up drives it high, the beat position is the starting low bits XOR the beat number. With the input low, the beat position is the starting low bits plus the beat number, wrapping within the four-beat block. When there is no advance and no load, the address holds. A load always takes priority over an advance on the same edge.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `addr_o` to zero from the following cycle.
- R2: When `load_i` is high at a rising edge, `addr_o` equals `addr_i` from the next cycle. That cycle is beat 0.
- R3: `adv_i` has no effect on the edge where `load_i` is high. The loaded address appears unchanged.
- R4: With `interleave_i` = 1, the low two bits after the n-th advance equal the start bits XOR n. From 01 the order is 01,00,11,10. From 10 it is 10,11,00,01.
- R5: With `interleave_i` = 0, the low two bits after the n-th advance equal (start + n) mod 4. From 11 the order is 11,00,01,10.
- R6: On an edge with `load_i` low and `adv_i` low, `addr_o` keeps its value (suspend).
- R7: Bits above the low two never change on an edge without a load.
- R8: A fifth beat, reached after four advances, returns the low bits to the starting value in either order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Captures `addr_i` as a new burst start |
| addr_i | input | ADDR_W (19) | External start address |
| adv_i | input | 1 | Steps to the next beat when no load is present |
| interleave_i | input | 1 | 1 selects XOR order, 0 selects wrapping linear order |
| addr_o | output | ADDR_W (19) | Current burst address |

## Verification
The assertions check these rules on every cycle:
- the reset value;
- that a load wins over an advance;
- that an advance always moves the low bits;
- that the address holds in suspend;
- that the upper bits stay fixed.

Only the bench scenarios can confirm the exact beat orders. These are the XOR order from two start values, the linear wrap from 11, and the return to the start after four advances. The bench compares them against tables written out by hand.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_hi_reg.sv
module bseq_hi_reg #(
  parameter int HI_W = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [HI_W-1:0] d_i,
  output logic [HI_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [BB-1:0] start_i,
  input  logic          step_i,
  output logic [BB-1:0] start_o,
  output logic [BB-1:0] beat_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_o <= '0;
      beat_o  <= '0;
    end else if (load_i) begin
      start_o <= start_i;
      beat_o  <= '0;
    end else if (step_i) begin
      beat_o  <= beat_o + 1'b1;
    end
  end
endmodule

// File: rtl/bseq_order.sv
module bseq_order
  import bseq_pkg::*;
#(
  parameter int BB = 2
) (
  input  logic [BB-1:0] start_i,
  input  logic [BB-1:0] beat_i,
  input  order_e        order_i,
  output logic [BB-1:0] low_o
);
  function automatic logic [BB-1:0] pos_xor(logic [BB-1:0] s, logic [BB-1:0] n);
    return s ^ n;
  endfunction

  function automatic logic [BB-1:0] pos_wrap(logic [BB-1:0] s, logic [BB-1:0] n);
    return s + n;
  endfunction

  always_comb begin
    case (order_i)
      ORDER_XOR: low_o = pos_xor(start_i, beat_i);
      default:   low_o = pos_wrap(start_i, beat_i);
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic                  load_evt;
  logic                  step_evt;
  logic                  hold_evt;
  logic [HI_W-1:0]       hi_q;
  logic [BURST_BITS-1:0] start_q;
  logic [BURST_BITS-1:0] beat_q;
  logic [BURST_BITS-1:0] low_w;
  order_e                order_w;

  assign load_evt = load_i;
  assign step_evt = adv_i & ~load_i;
  assign hold_evt = ~adv_i & ~load_i;
  assign order_w  = order_e'(interleave_i);

  bseq_hi_reg #(.HI_W(HI_W)) u_hi (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_evt),
    .d_i    (addr_i[ADDR_W-1:BURST_BITS]),
    .q_o    (hi_q)
  );

  bseq_beat_ctr #(.BB(BURST_BITS)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_evt),
    .start_i (addr_i[BURST_BITS-1:0]),
    .step_i  (step_evt),
    .start_o (start_q),
    .beat_o  (beat_q)
  );

  bseq_order #(.BB(BURST_BITS)) u_ord (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order_w),
    .low_o   (low_w)
  );

  assign addr_o = {hi_q, low_w};
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
  parameter int ADDR_W     = 19,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              step_evt,
  input logic              hold_evt
);
  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> addr_o == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> addr_o == $past(addr_i));

  p_adv_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (load_i && adv_i) |=> addr_o[BURST_BITS-1:0] == $past(addr_i[BURST_BITS-1:0]));

  p_step_moves_r4: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> addr_o[BURST_BITS-1:0] != $past(addr_o[BURST_BITS-1:0]));

  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> $stable(addr_o));

  p_upper_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(addr_o[ADDR_W-1:BURST_BITS]));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_i   (load_i),
  .adv_i    (adv_i),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .step_evt (step_evt),
  .hold_evt (hold_evt)
);

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
  localparam int AW = 19;
  localparam int VW = 3 + 4 + AW + AW;
  localparam int NV = 21;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_i;
  logic [AW-1:0] addr_i;
  logic          adv_i;
  logic          interleave_i;
  logic [AW-1:0] addr_o;
  int            checks = 0;
  int            errors = 0;

  always #5 clk = ~clk;

  burst_addr_seq u_dut (
    .clk          (clk),
    .rst          (rst),
    .load_i       (load_i),
    .addr_i       (addr_i),
    .adv_i        (adv_i),
    .interleave_i (interleave_i),
    .addr_o       (addr_o)
  );

  // {load, adv, interleave, req, addr_i, expected addr_o one cycle later}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,4'd3,19'h12345,19'h12345}, // R3: advance ignored on load, XOR start 01
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h12344}, // R4: 00
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h12347}, // R4: 11
    {1'b0,1'b0,1'b1,4'd6,19'h00000,19'h12347}, // R6: suspend
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h12346}, // R4: 10
    {1'b0,1'b1,1'b1,4'd8,19'h00000,19'h12345}, // R8: wrap to start
    {1'b0,1'b0,1'b1,4'd7,19'h7FFFF,19'h12345}, // R7: addr_i ignored without load
    {1'b1,1'b0,1'b1,4'd2,19'h04A6A,19'h04A6A}, // R2: load, start 10
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h04A6B}, // R4: 11
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h04A68}, // R4: 00
    {1'b0,1'b1,1'b1,4'd4,19'h00000,19'h04A69}, // R4: 01
    {1'b1,1'b0,1'b0,4'd2,19'h7FFFF,19'h7FFFF}, // R2: linear, start 11
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h7FFFC}, // R5: 00, upper unchanged
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h7FFFD}, // R5: 01
    {1'b0,1'b0,1'b0,4'd6,19'h00000,19'h7FFFD}, // R6: suspend
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h7FFFE}, // R5: 10
    {1'b0,1'b1,1'b0,4'd8,19'h00000,19'h7FFFF}, // R8: linear wrap
    {1'b1,1'b1,1'b0,4'd3,19'h00101,19'h00101}, // R3: load wins, start 01
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h00102}, // R5: 10
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h00103}, // R5: 11
    {1'b0,1'b1,1'b0,4'd5,19'h00000,19'h00100}  // R5: 00
  };

  task automatic check(input int req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    rst = 1'b1; load_i = 1'b0; adv_i = 1'b0; interleave_i = 1'b1; addr_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, addr_o, '0); // R1: reset state
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      load_i       = v[VW-1];
      adv_i        = v[VW-2];
      interleave_i = v[VW-3];
      addr_i       = v[2*AW-1:AW];
      @(posedge clk);
      @(negedge clk);
      check(int'(v[VW-4 -: 4]), addr_o, v[AW-1:0]);
    end
    // R1: reset mid-burst clears a nonzero address
    load_i = 1'b0; adv_i = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; adv_i = 1'b0;
    check(1, addr_o, '0);
    // R6: long suspend after reset keeps zero
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(6, addr_o, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule